// File: doc/BRIEF.md
# Token-Passing Chained FIFO

This block is a deep first-in/first-out buffer built from several identical storage cells joined in a ring. All cells see the same write strobe, read strobe and data buses. Exactly one cell at a time owns the right to accept writes, and exactly one owns the right to supply reads. A cell's owned pointer reaches its last location, and the cell then emits a one-cycle low pulse on its expansion output. That pulse hands the matching right to the next cell in the ring. The last cell feeds the first.

Each cell keeps its own occupancy and its own active-low empty and full flags. A combiner merges them into chain-wide flags. The chain-wide flag asserts only when every cell asserts its own. The designer marks the starting cell by driving its bit of the first-load vector low during reset. All operations are synchronous to one clock. When the read strobe is high and accepted, read data appears combinationally in the same cycle. At all other times the read bus is driven to zero, which stands in for the released bus.

Top module: `fifo_token_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, every cell clears its pointers and occupancy. After release, `empty_n` is 0, `full_n` is 1, `rd_data` is 0 and all bits of `xo_n` are 1. Both rights start at the cell whose `load_first_n` bit was 0 during reset.
- R2: An accepted write stores into the cell owning the write right. After that cell fills locations 0 to CELL_DEPTH-1 in order, the write right moves to cell (index+1) mod N_CELLS.
- R3: Reads return words in exactly the order they were written, including across cell boundaries and around the ring.
- R4: `xo_n[c]` is 0 for exactly the cycle in which cell c accepts a write or a read at location CELL_DEPTH-1. No more than one bit of `xo_n` is 0 in any cycle.
- R5: `full_n` is 0 exactly when the chain holds N_CELLS*CELL_DEPTH words. A write strobe while full stores nothing, so later reads return no extra word.
- R6: `empty_n` is 0 exactly when the chain holds no words. A read strobe while empty changes nothing, and `rd_data` stays 0.
- R7: During a cycle with `rd_en`=1 that is accepted, `rd_data` shows the oldest word, and that word is removed at the clock edge. In any other cycle `rd_data` is 0.
- R8: When `wr_en` and `rd_en` are both 1 in the same cycle, only the write takes effect. The read is not performed and `rd_data` is 0.
- R9: With a starting cell other than cell 0, the first word is stored in that cell. The rights then move around the ring from there, and ordering still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_first_n | input | N_CELLS | Active-low starting-cell select, sampled during reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data; zero when no read is accepted |
| empty_n | output | 1 | Chain empty, active low |
| full_n | output | 1 | Chain full, active low |
| xo_n | output | N_CELLS | Per-cell expansion pulse, active low |

## Verification
The bench targets the handover cycles. One is a write to a cell's last location while the next cell is still empty. Another is a read of a last location followed at once by the next read. A design that moved the right a cycle late, or to the wrong cell, would return a stale or out-of-order word at the boundary. A design that pulsed on the wrong location would show a shifted `xo_n`. The bench also covers writes into a full chain, reads from an empty chain, and cycles with both strobes high. A design that lost the write priority would drop or duplicate a word. A design that mis-decoded the pulse direction would hand a right to the wrong side. A second reset with a different starting cell catches a design that ignores the first-load select.

// File: rtl/fifo_token_chain.sv
module fifo_token_chain #(
  parameter int N_CELLS    = 3,
  parameter int CELL_DEPTH = 4,
  parameter int DATA_W     = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CELLS-1:0]  load_first_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                empty_n,
  output logic                full_n,
  output logic [N_CELLS-1:0]  xo_n
);
  localparam int PTR_W = (CELL_DEPTH > 1) ? $clog2(CELL_DEPTH) : 1;
  localparam int CNT_W = $clog2(CELL_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(CELL_DEPTH - 1);

  logic              rd_go;
  logic [N_CELLS-1:0] wtok, rtok, cell_ef_n, cell_ff_n, wr_hit, rd_hit, xi_n;
  logic [DATA_W-1:0]  drive [N_CELLS];

  assign rd_go = rd_en & ~wr_en;

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    localparam int PREV = (c + N_CELLS - 1) % N_CELLS;
    logic [DATA_W-1:0] mem [CELL_DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  cnt;
    logic              wt, rt;

    assign wtok[c]      = wt;
    assign rtok[c]      = rt;
    assign xi_n[c]      = xo_n[PREV];
    assign cell_ef_n[c] = (cnt != '0);
    assign cell_ff_n[c] = (cnt != CNT_W'(CELL_DEPTH));
    assign wr_hit[c]    = wr_en & wt & cell_ff_n[c];
    assign rd_hit[c]    = rd_go & rt & cell_ef_n[c];
    assign xo_n[c]      = ~((wr_hit[c] && wptr == LAST) || (rd_hit[c] && rptr == LAST));
    assign drive[c]     = rd_hit[c] ? mem[rptr] : '0;

    always_ff @(posedge clk)
      if (wr_hit[c]) mem[wptr] <= wr_data;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
        wt   <= ~load_first_n[c];
        rt   <= ~load_first_n[c];
      end else begin
        if (wr_hit[c]) begin
          wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
          if (wptr == LAST) wt <= 1'b0;
        end
        if (rd_hit[c]) begin
          rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
          if (rptr == LAST) rt <= 1'b0;
        end
        if (!xi_n[c] && wr_en) wt <= 1'b1;
        if (!xi_n[c] && rd_go) rt <= 1'b1;
        cnt <= cnt + CNT_W'(wr_hit[c]) - CNT_W'(rd_hit[c]);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CELLS; i++) rd_data |= drive[i];
  end

  assign empty_n = |cell_ef_n;
  assign full_n  = |cell_ff_n;
endmodule

// File: rtl/fifo_token_chain_chk.sv
module fifo_token_chain_chk #(
  parameter int N_CELLS = 3,
  parameter int DATA_W  = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic               empty_n,
  input logic               full_n,
  input logic [N_CELLS-1:0] xo_n,
  input logic [N_CELLS-1:0] wtok,
  input logic [N_CELLS-1:0] rtok
);
  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!empty_n && full_n)); // R1
  AST_WTOK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wtok)); // R2
  AST_RTOK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(rtok)); // R3
  AST_XO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~xo_n)); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !rd_en) |=> !full_n); // R5
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> (rd_data == '0)); // R6
endmodule

bind fifo_token_chain fifo_token_chain_chk #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n),
  .full_n(full_n), .xo_n(xo_n), .wtok(wtok), .rtok(rtok));

// File: tb/test_fifo_token_chain.sv
module test_fifo_token_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int D = 4;
  localparam int W = 9;
  localparam int TOT = N * D;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [N-1:0] load_first_n = '1;
  logic [W-1:0] wr_data = '0, rd_data;
  logic empty_n, full_n;
  logic [N-1:0] xo_n;

  int checks = 0, errors = 0;
  logic [W-1:0] q[$];
  int wpos = 0, rpos = 0;
  logic [W-1:0] seq = 0;

  fifo_token_chain #(.N_CELLS(N), .CELL_DEPTH(D), .DATA_W(W)) i_fifo_token_chain (
    .clk(clk), .rst_n(rst_n), .load_first_n(load_first_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n),
    .full_n(full_n), .xo_n(xo_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(int first);
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    load_first_n = '1;
    load_first_n[first] = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    q.delete();
    wpos = first * D; rpos = first * D;
    #1;
    check("R1 empty_n", empty_n, 0);
    check("R1 full_n", full_n, 1);
    check("R1 rd_data", rd_data, 0);
    check("R1 xo_n", xo_n, {N{1'b1}});
  endtask

  task automatic step(logic w, logic r);
    logic wacc, racc;
    logic [N-1:0] exp_xo;
    logic [W-1:0] exp_rd;
    @(negedge clk);
    wr_en = w; rd_en = r;
    if (w) begin wr_data = seq; end
    wacc = w && (q.size() < TOT);
    racc = r && !w && (q.size() > 0);
    exp_rd = racc ? q[0] : '0;
    exp_xo = '1;
    if (wacc && (wpos % D) == D-1) exp_xo[wpos / D] = 1'b0;
    if (racc && (rpos % D) == D-1) exp_xo[rpos / D] = 1'b0;
    #1;
    check(r && w ? "R8 rd_data" : (q.size() == 0 ? "R6 rd_data" : "R3 R7 rd_data"), rd_data, exp_rd);
    check("R6 empty_n", empty_n, q.size() != 0);
    check("R5 full_n", full_n, q.size() != TOT);
    check("R2 R4 R9 xo_n", xo_n, exp_xo);
    if (wacc) begin q.push_back(seq); wpos = (wpos + 1) % TOT; end
    if (racc) begin void'(q.pop_front()); rpos = (rpos + 1) % TOT; end
    if (w) seq = seq + 9'd37;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(0);
    for (int i = 0; i < TOT + 3; i++) step(1, 0);
    for (int i = 0; i < TOT + 3; i++) step(0, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 4; i++) step(1, 1);
    for (int i = 0; i < 2000; i++) begin
      int v = $urandom_range(0, 9);
      step(v < 5, v >= 4);
    end
    do_reset(2);
    for (int i = 0; i < 7; i++) step(1, 0);
    for (int i = 0; i < 3; i++) step(0, 1);
    for (int i = 0; i < 10; i++) step(1, 0);
    for (int i = 0; i < TOT + 2; i++) step(0, 1);
    for (int i = 0; i < 1000; i++) begin
      int v = $urandom_range(0, 9);
      step(v < 6, v >= 3);
    end
    do_reset(1);
    for (int i = 0; i < 3 * TOT; i++) step(i % 3 != 2, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule